// File: doc/BRIEF.md
# Serial Port Register Block

This block is the software-visible face of a serial port. A 32-bit word-access bus reaches a small set of control words and a 16-byte receive queue. It also reaches a status/data word that comes in two aliases: one shows the oldest received byte without removing it, and the other removes it. A transmit byte leaves on a one-cycle strobe when software writes the data-out word. The bit-level serializer, the deserializer, baud timing and DMA sit outside this block.

Interrupts follow a raw/mask/acknowledge scheme that drives one level output. The receive-data bit is a live level: it is high exactly while the queue holds a byte. Two bits are set by a transmit. The first acknowledge after a transmit cannot clear the low transmit bit, so software must acknowledge a second time to clear it.

The bus read path is combinational. A read at the popping alias takes effect at the clock edge that completes the access.

Top module: `ser_port_regs`

## Requirements
- R1: After reset the receive control word (byte offset 0x08) reads 0x00010000, and the mask (0x2C), raw interrupt (0x34) and masked interrupt (0x38) words read 0. `irq_o` is low, and the peek word (0x24) reads 0x01400000 in bits 31:8.
- R2: The transmit control (0x00), transmit DMA enable (0x04), receive control (0x08), data-out (0x1C) and mask (0x2C) words read back the last value written. Writes to the read-only words 0x20, 0x24, 0x34 and 0x38 are ignored. Unmapped offsets, including 0x3C and above, read 0 and ignore writes. Address bits 1:0 are ignored.
- R3: A read at 0x24 returns the oldest queued byte in bits 7:0, with bit 16 set when the queue is non-empty and bits 22 and 24 always 1. It leaves the queue unchanged.
- R4: A read at 0x20 returns the same word as 0x24 and removes the oldest byte when the queue is non-empty. On an empty queue it changes nothing.
- R5: The queue returns bytes in arrival order and holds 16 bytes. A byte that arrives while 16 are stored is discarded.
- R6: A byte presented on `rx_valid_i` is accepted only while bit 3 of the receive control word is 1.
- R7: Raw interrupt bit 3 is 1 exactly while the queue holds at least one byte.
- R8: Writing 0x1C drives `tx_valid_o` high for the one cycle after the write, with `tx_byte_o` equal to the written bits 7:0. The write also sets raw interrupt bits 0 and 1 and arms a pending-transmit flag.
- R9: Writing 0x30 clears the raw bits written as 1. While the pending-transmit flag is armed, bit 0 is dropped from the written value and the flag is disarmed. The word at 0x30 reads back the value after that adjustment.
- R10: The masked word equals raw AND mask, and `irq_o` is high exactly when the masked word is non-zero.
- R11: A pop read and an accepted byte in the same cycle return the old head byte and leave the count unchanged, with the new byte queued behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (6) | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational for the current access |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_byte_o | output | 8 | Transmit byte |
| irq_o | output | 1 | Interrupt level |

## Verification
The assertions assume that the bus holds address, direction and data stable for the whole cycle in which `req_i` is high, and that `rx_valid_i` is a single-cycle strobe sampled at the rising edge. The bench drives every access and every received byte at the falling edge and releases it one time unit after the next rising edge. Each access and each byte therefore occupies exactly one edge. The bench makes a pop read and a received byte coincide only on purpose, in the dedicated same-cycle case.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;
  localparam int unsigned WORD_W = 32;

  // word index = byte offset / 4
  typedef enum logic [3:0] {
    IDX_TX_CTRL   = 4'h0,
    IDX_TX_DMA    = 4'h1,
    IDX_RX_CTRL   = 4'h2,
    IDX_DOUT      = 4'h7,
    IDX_STAT_POP  = 4'h8,
    IDX_STAT_PEEK = 4'h9,
    IDX_MASK      = 4'hB,
    IDX_ACK       = 4'hC,
    IDX_RAW       = 4'hD,
    IDX_MASKED    = 4'hE
  } reg_idx_e;

  localparam int unsigned REGION_WORDS = 15;
  localparam int unsigned ST_AVAIL     = 16;
  localparam int unsigned ST_TX_IDLE   = 22;
  localparam int unsigned ST_TX_RDY    = 24;
  localparam int unsigned RX_EN_BIT    = 3;
  localparam int unsigned IRQ_RX_BIT   = 3;
  localparam logic [WORD_W-1:0] RX_CTRL_RST = 32'h0001_0000;
endpackage

// File: rtl/ser_rx_fifo.sv
module ser_rx_fifo #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic              push_ok_o,
  output logic              pop_ok_o,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              empty_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign full      = (cnt_q == FULL_CNT);
  assign empty_o   = (cnt_q == '0);
  // fullness judged on the pre-edge count: a full queue drops a same-cycle byte
  assign push_ok_o = push_i && !full;
  assign pop_ok_o  = pop_i && !empty_o;
  assign head_o    = mem_q[rd_ptr_q];
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (push_ok_o) begin
      mem_q[wr_ptr_q] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok_o) wr_ptr_q <= bump(wr_ptr_q);
      if (pop_ok_o)  rd_ptr_q <= bump(rd_ptr_q);
      unique case ({push_ok_o, pop_ok_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/ser_irq_ctrl.sv
module ser_irq_ctrl
  import ser_port_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tx_fire_i,
  input  logic         ack_fire_i,
  input  logic [W-1:0] ack_val_i,
  input  logic         rx_nonempty_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] ack_eff_o,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] masked_o,
  output logic         pend_o,
  output logic         irq_o
);
  logic [1:0] tx_bits_q;
  logic       pend_q;

  // an armed transmit shields bit 0 from the first acknowledge
  always_comb begin
    ack_eff_o = ack_val_i;
    if (pend_q) ack_eff_o[0] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_bits_q <= '0;
      pend_q    <= 1'b0;
    end else if (tx_fire_i) begin
      tx_bits_q <= 2'b11;
      pend_q    <= 1'b1;
    end else if (ack_fire_i) begin
      tx_bits_q <= tx_bits_q & ~ack_eff_o[1:0];
      pend_q    <= 1'b0;
    end
  end

  always_comb begin
    raw_o             = '0;
    raw_o[1:0]        = tx_bits_q;
    raw_o[IRQ_RX_BIT] = rx_nonempty_i;
  end

  assign masked_o = raw_o & mask_i;
  assign irq_o    = |masked_o;
  assign pend_o   = pend_q;
endmodule

// File: rtl/ser_tx_port.sv
module ser_tx_port #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_byte_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_byte_o  <= '0;
    end else begin
      tx_valid_o <= fire_i;
      if (fire_i) tx_byte_o <= data_i;
    end
  end
endmodule

// File: rtl/ser_port_regs.sv
module ser_port_regs
  import ser_port_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned RX_DEPTH = 16,
  parameter int unsigned BYTE_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              irq_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam int unsigned CNT_W = $clog2(RX_DEPTH) + 1;
  localparam logic [IDX_W-1:0] REGION_LIM = IDX_W'(REGION_WORDS);

  logic [IDX_W-1:0]  widx_full;
  logic [3:0]        widx;
  logic              hit, wr_en, rd_en;
  logic              dout_wr, ack_wr, pop_req, push_req;
  logic              push_ok, pop_ok, rx_empty, rx_en, pend;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] head;
  logic [31:0]       tx_ctrl_q, tx_dma_q, rx_ctrl_q, dout_q, mask_q, ack_q;
  logic [31:0]       ack_eff, raw, masked, stat;

  assign widx_full = addr_i[ADDR_W-1:2];
  assign widx      = widx_full[3:0];
  assign hit       = (widx_full < REGION_LIM);
  assign wr_en     = req_i && we_i && hit;
  assign rd_en     = req_i && !we_i && hit;
  assign dout_wr   = wr_en && (widx == IDX_DOUT);
  assign ack_wr    = wr_en && (widx == IDX_ACK);
  assign pop_req   = rd_en && (widx == IDX_STAT_POP);
  assign rx_en     = rx_ctrl_q[RX_EN_BIT];
  assign push_req  = rx_valid_i && rx_en;

  ser_rx_fifo #(.DEPTH(RX_DEPTH), .DATA_W(BYTE_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push_req), .data_i(rx_byte_i), .pop_i(pop_req),
    .push_ok_o(push_ok), .pop_ok_o(pop_ok),
    .head_o(head), .cnt_o(cnt), .empty_o(rx_empty)
  );

  ser_irq_ctrl #(.W(32)) u_irq (
    .clk_i, .rst_ni,
    .tx_fire_i(dout_wr), .ack_fire_i(ack_wr), .ack_val_i(wdata_i),
    .rx_nonempty_i(!rx_empty), .mask_i(mask_q),
    .ack_eff_o(ack_eff), .raw_o(raw), .masked_o(masked),
    .pend_o(pend), .irq_o(irq_o)
  );

  ser_tx_port #(.DATA_W(BYTE_W)) u_tx (
    .clk_i, .rst_ni,
    .fire_i(dout_wr), .data_i(wdata_i[BYTE_W-1:0]),
    .tx_valid_o, .tx_byte_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_ctrl_q <= '0;
      tx_dma_q  <= '0;
      rx_ctrl_q <= RX_CTRL_RST;
      dout_q    <= '0;
      mask_q    <= '0;
      ack_q     <= '0;
    end else if (wr_en) begin
      unique case (widx)
        IDX_TX_CTRL: tx_ctrl_q <= wdata_i;
        IDX_TX_DMA:  tx_dma_q  <= wdata_i;
        IDX_RX_CTRL: rx_ctrl_q <= wdata_i;
        IDX_DOUT:    dout_q    <= wdata_i;
        IDX_MASK:    mask_q    <= wdata_i;
        IDX_ACK:     ack_q     <= ack_eff;
        default: ;
      endcase
    end
  end

  always_comb begin
    stat             = '0;
    stat[BYTE_W-1:0] = head;
    stat[ST_AVAIL]   = !rx_empty;
    stat[ST_TX_IDLE] = 1'b1;
    stat[ST_TX_RDY]  = 1'b1;
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      unique case (widx)
        IDX_TX_CTRL:   rdata_o = tx_ctrl_q;
        IDX_TX_DMA:    rdata_o = tx_dma_q;
        IDX_RX_CTRL:   rdata_o = rx_ctrl_q;
        IDX_DOUT:      rdata_o = dout_q;
        IDX_STAT_POP,
        IDX_STAT_PEEK: rdata_o = stat;
        IDX_MASK:      rdata_o = mask_q;
        IDX_ACK:       rdata_o = ack_q;
        IDX_RAW:       rdata_o = raw;
        IDX_MASKED:    rdata_o = masked;
        default:       rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/ser_port_regs_chk.sv
module ser_port_regs_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en,
  input logic             rd_en,
  input logic [3:0]       widx,
  input logic [31:0]      wdata_i,
  input logic             rx_valid_i,
  input logic             rx_en,
  input logic             push_ok,
  input logic             pop_ok,
  input logic [CNT_W-1:0] cnt,
  input logic             pend,
  input logic [31:0]      raw,
  input logic             tx_valid_o,
  input logic [7:0]       tx_byte_o
);
  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(DEPTH));

  a_r4_pop_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_ok && !push_ok |=> cnt == $past(cnt) - 1'b1);

  a_r11_push_pop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_ok && push_ok |=> $stable(cnt));

  a_r6_rx_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !rx_en |-> !push_ok);

  a_r3_peek_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en && widx == 4'h9 |-> !pop_ok);

  a_r8_tx_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en && widx == 4'h7 |=> tx_valid_o && tx_byte_o == $past(wdata_i[7:0]));

  a_r9_first_ack_keeps_bit0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en && widx == 4'hC && pend |=> raw[0] == $past(raw[0]) && !pend);
endmodule

bind ser_port_regs ser_port_regs_chk #(.DEPTH(RX_DEPTH)) u_chk (
  .clk_i, .rst_ni, .wr_en, .rd_en, .widx, .wdata_i, .rx_valid_i,
  .rx_en, .push_ok, .pop_ok, .cnt, .pend, .raw, .tx_valid_o, .tx_byte_o
);

// File: tb/sim_ser_port_regs.sv
`timescale 1ns/1ps
module sim_ser_port_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  ser_port_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .tx_valid_o(tx_valid), .tx_byte_o(tx_byte), .irq_o(irq)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp,
                     input logic [31:0] m = 32'hFFFF_FFFF);
    n_chk++;
    if ((act & m) !== (exp & m)) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act & m, exp & m);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1 req = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] v);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = v;
    if (a == 6'h1C) exp_q.push_back(v[7:0]);
    @(posedge clk); #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic rx(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(posedge clk); #1 rx_valid = 1'b0;
  endtask

  task automatic pop_and_rx(input logic [7:0] b, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = 6'h20; rx_valid = 1'b1; rx_byte = b;
    #1 d = rdata;
    @(posedge clk); #1 req = 1'b0; rx_valid = 1'b0;
  endtask

  // scoreboard monitor for transmit strobes (R8)
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R8 unexpected tx actual=%h expected=none", tx_byte);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (tx_byte !== e) begin
          n_bad++;
          $display("FAIL R8 tx byte actual=%h expected=%h", tx_byte, e);
        end
      end
    end
  end

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    #7 rst_n = 1'b1;

    // R1 reset state
    rd(6'h08, d); chk("R1 rx ctrl", d, 32'h0001_0000);
    rd(6'h2C, d); chk("R1 mask", d, 0);
    rd(6'h34, d); chk("R1 raw", d, 0);
    rd(6'h38, d); chk("R1 masked", d, 0);
    rd(6'h24, d); chk("R1 status", d, 32'h0140_0000, 32'hFFFF_FF00);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 readback, read-only and unmapped words
    wr(6'h00, 32'hA5A5_1234); rd(6'h00, d); chk("R2 tx ctrl", d, 32'hA5A5_1234);
    wr(6'h04, 32'h0000_0F0F); rd(6'h07, d); chk("R2 dma low bits ignored", d, 32'h0000_0F0F);
    wr(6'h34, 32'hFFFF_FFFF); rd(6'h34, d); chk("R2 raw read-only", d, 0);
    wr(6'h0C, 32'h1234_5678); rd(6'h0C, d); chk("R2 unmapped", d, 0);
    wr(6'h3C, 32'h1234_5678); rd(6'h3C, d); chk("R2 out of region", d, 0);

    // R6 receiver disabled drops bytes
    rx(8'h11); rd(6'h24, d); chk("R6 disabled", d, 32'h0140_0000, 32'hFFFF_FF00);
    wr(6'h08, 32'h0001_0008); rd(6'h08, d); chk("R2 rx ctrl", d, 32'h0001_0008);

    // R3 peek, R4 pop, R7 raw bit
    rx(8'h41); rx(8'h42); rx(8'h43);
    rd(6'h24, d); chk("R3 peek", d, 32'h0141_0041);
    rd(6'h24, d); chk("R3 peek again", d, 32'h0141_0041);
    rd(6'h34, d); chk("R7 raw nonempty", d, 32'h8);
    rd(6'h20, d); chk("R4 pop", d, 32'h0141_0041);
    rd(6'h24, d); chk("R4 next head", d, 32'h0141_0042);
    rd(6'h20, d); chk("R4 pop 2", d, 32'h0141_0042);
    rd(6'h20, d); chk("R4 pop 3", d, 32'h0141_0043);
    rd(6'h34, d); chk("R7 raw empty", d, 0);
    rd(6'h20, d); chk("R4 empty pop", d, 32'h0140_0000, 32'hFFFF_FF00);
    rd(6'h24, d); chk("R4 still empty", d, 32'h0140_0000, 32'hFFFF_FF00);

    // R5 capacity, order, overflow drop
    for (int i = 0; i < 16; i++) rx(8'h50 + 8'(i));
    rx(8'hEE);
    for (int i = 0; i < 16; i++) begin
      rd(6'h20, d); chk("R5 order", d, 32'h0141_0050 + 32'(i));
    end
    rd(6'h24, d); chk("R5 overflow dropped", d, 32'h0140_0000, 32'hFFFF_FF00);

    // R11 same-cycle pop and receive
    rx(8'h61);
    pop_and_rx(8'h62, d); chk("R11 pop old head", d, 32'h0141_0061);
    rd(6'h24, d); chk("R11 new head", d, 32'h0141_0062);
    rd(6'h20, d); chk("R11 drain", d, 32'h0141_0062);
    rd(6'h24, d); chk("R11 empty", d, 32'h0140_0000, 32'hFFFF_FF00);

    // R8 transmit
    wr(6'h1C, 32'h1234_56C3);
    rd(6'h34, d); chk("R8 raw tx bits", d, 32'h3);
    rd(6'h1C, d); chk("R2 dout readback", d, 32'h1234_56C3);

    // R9 acknowledge quirk
    wr(6'h30, 32'h3); rd(6'h34, d); chk("R9 first ack keeps bit0", d, 32'h1);
    rd(6'h30, d); chk("R9 ack readback", d, 32'h2);
    wr(6'h30, 32'h1); rd(6'h34, d); chk("R9 second ack", d, 0);
    rd(6'h30, d); chk("R9 ack readback 2", d, 32'h1);
    wr(6'h1C, 32'h0000_005A);
    wr(6'h30, 32'h2); rd(6'h34, d); chk("R9 ack bit1", d, 32'h1);
    wr(6'h30, 32'h1); rd(6'h34, d); chk("R9 ack bit0", d, 0);

    // R10 mask and irq
    wr(6'h2C, 32'h8); rx(8'h77);
    chk("R10 irq rx", {31'b0, irq}, 1);
    rd(6'h38, d); chk("R10 masked rx", d, 32'h8);
    wr(6'h2C, 32'h2);
    chk("R10 irq masked off", {31'b0, irq}, 0);
    rd(6'h38, d); chk("R10 masked none", d, 0);
    wr(6'h1C, 32'h0000_0099);
    rd(6'h34, d); chk("R10 raw", d, 32'hB);
    rd(6'h38, d); chk("R10 masked tx", d, 32'h2);
    chk("R10 irq tx", {31'b0, irq}, 1);
    wr(6'h30, 32'h3);
    rd(6'h34, d); chk("R9 raw after ack", d, 32'h9);
    chk("R10 irq cleared", {31'b0, irq}, 0);
    rd(6'h20, d); chk("R4 drain 77", d, 32'h0141_0077);

    repeat (3) @(negedge clk);
    chk("R8 tx queue drained", 32'(exp_q.size()), 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule